// File: doc/BRIEF.md
# Release-Triggered Key Encoder

This block watches a bank of independent push-button lines, each pulled high and driven low while its button is held. It reports a key only once the key has been let go. When a single key goes down and comes back up, the block stores that key's number in a small output register that a host may read at any time. It also raises a strobe for one clock cycle in the same cycle the register takes its new value. Key numbering starts at one, so the line at bit position *i* reports the code *i*+1. On a 4-bit code the last of sixteen lines wraps to zero.

Each raw line passes through a two-stage synchroniser. A debouncer then accepts a new pattern only after the synchronised lines have held it for a programmable number of cycles. A small state machine works on the debounced pattern. It captures the key index on press, waits for release, and publishes the code. If two or more keys are down at once, whether together or because one joins a held key, the machine drops the press and stays silent until every key is up.

Top module: `key_release_encoder`

## Requirements
- R1: While reset is high at a clock edge, the key code register becomes 0000 and the new-key strobe becomes 0.
- R2: After a lone key at bit index i (active low, i from 0 to 14) is pressed and fully released, the code output equals i+1 as an unsigned 4-bit value. Examples: bit 1 gives 0010 and bit 5 gives 0110.
- R3: While a key is still held, the code output and the strobe do not change.
- R4: A lone press and release of the key at bit index 15 publishes code 0000 with a strobe.
- R5: The strobe is high for exactly one cycle per completed lone press/release, in the cycle the new code first appears.
- R6: If more than one key line is low when a press is first accepted, no code or strobe is produced until all lines are high. A following lone key then encodes normally.
- R7: A low pulse shorter than DEB_LEN cycles on a key line is ignored: no strobe and no code change.
- R8: The code register holds its last value in every cycle without a strobe.
- R9: If a second key goes low while an accepted key is still held, that press is abandoned and gives no code and no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| keys_n | input | NUM_KEYS | Raw key lines, low while pressed |
| key_code | output | CODE_W | Last completed key number, active high |
| new_key | output | 1 | One-cycle strobe, high when key_code updates |

## Verification
The bench goes after the wrap of the top key to zero. A design that simply sized the output for sixteen would truncate that code wrongly or widen the port. It checks that the code stays put while a key is held, which catches a design that publishes on press. Short glitches are aimed at the debouncer; a counter that compared against the wrong limit would let them through as keys. Simultaneous presses and a key joining a held one probe the lockout path. A machine missing it would report the lowest or the first key, or emit a strobe with a stale code.

// File: rtl/kenc_pkg.sv
package kenc_pkg;

    localparam int KENC_DEF_KEYS    = 16;
    localparam int KENC_DEF_DEB_LEN = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HELD     = 2'd1,
        ST_RELEASED = 2'd2,
        ST_LOCKOUT  = 2'd3
    } kenc_state_e;

    typedef struct packed {
        logic single;
        logic none;
    } kenc_press_t;

endpackage

// File: rtl/kenc_sync.sv
module kenc_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= d_in;
            stage2 <= stage1;
        end
    end

    assign d_out = stage2;
endmodule

// File: rtl/kenc_debounce.sv
module kenc_debounce #(
    parameter int W       = 16,
    parameter int DEB_LEN = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    localparam int CNT_W = $clog2(DEB_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

    logic [W-1:0]     cand;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand    <= '1;
            cnt     <= '0;
            clean_q <= '1;
        end else if (raw != cand) begin
            cand <= raw;
            cnt  <= '0;
        end else if (cnt == CNT_LAST) begin
            clean_q <= cand;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign clean = clean_q;
endmodule

// File: rtl/kenc_fsm.sv
module kenc_fsm
    import kenc_pkg::*;
#(
    parameter int NUM_KEYS = 16,
    parameter int CODE_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] deb_n,
    output logic [CODE_W-1:0]   key_code,
    output logic                new_key,
    output kenc_state_e         state
);
    logic [NUM_KEYS-1:0] pressed;
    kenc_press_t         pinfo;
    logic [CODE_W-1:0]   low_idx;
    logic [CODE_W-1:0]   idx_q;
    logic                same_key;
    kenc_state_e         st_q;
    kenc_state_e         st_d;

    always_comb begin
        pressed      = ~deb_n;
        pinfo.none   = (pressed == '0);
        pinfo.single = !pinfo.none && ((pressed & (pressed - NUM_KEYS'(1))) == '0);
        low_idx      = '0;
        for (int i = NUM_KEYS - 1; i >= 0; i--) begin
            if (pressed[i]) low_idx = CODE_W'(i);
        end
        same_key = (pressed == (NUM_KEYS'(1) << idx_q));
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (pinfo.single)     st_d = ST_HELD;
                else if (!pinfo.none) st_d = ST_LOCKOUT;
            end
            ST_HELD: begin
                if (pinfo.none)     st_d = ST_RELEASED;
                else if (!same_key) st_d = ST_LOCKOUT;
            end
            ST_RELEASED: st_d = ST_IDLE;
            ST_LOCKOUT: begin
                if (pinfo.none) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            idx_q    <= '0;
            key_code <= '0;
            new_key  <= 1'b0;
        end else begin
            st_q    <= st_d;
            new_key <= 1'b0;
            if (st_q == ST_IDLE && pinfo.single) idx_q <= low_idx;
            if (st_q == ST_RELEASED) begin
                key_code <= idx_q + CODE_W'(1);
                new_key  <= 1'b1;
            end
        end
    end

    assign state = st_q;
endmodule

// File: rtl/key_release_encoder.sv
module key_release_encoder
    import kenc_pkg::*;
#(
    parameter int NUM_KEYS = KENC_DEF_KEYS,
    parameter int DEB_LEN  = KENC_DEF_DEB_LEN,
    parameter int CODE_W   = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] keys_n,
    output logic [CODE_W-1:0]   key_code,
    output logic                new_key
);
    logic [NUM_KEYS-1:0] sync_n;
    logic [NUM_KEYS-1:0] deb_n;
    kenc_state_e         fsm_state;

    kenc_sync #(.W(NUM_KEYS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (keys_n),
        .d_out (sync_n)
    );

    kenc_debounce #(.W(NUM_KEYS), .DEB_LEN(DEB_LEN)) u_deb (
        .clk   (clk),
        .rst   (rst),
        .raw   (sync_n),
        .clean (deb_n)
    );

    kenc_fsm #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .deb_n    (deb_n),
        .key_code (key_code),
        .new_key  (new_key),
        .state    (fsm_state)
    );
endmodule

// File: rtl/kenc_checker.sv
module kenc_checker
    import kenc_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] key_code,
    input logic              new_key,
    input kenc_state_e       fsm_st
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (key_code == '0) && !new_key);

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        new_key |=> !new_key);

    a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
        !new_key |-> $stable(key_code));

    a_r3_quiet_while_held: assert property (@(posedge clk) disable iff (rst)
        (fsm_st == ST_HELD) |-> !new_key);

    a_r6_lockout_silent: assert property (@(posedge clk) disable iff (rst)
        (fsm_st == ST_LOCKOUT) |=> !new_key);

    a_r5_strobe_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(new_key) |-> $past(fsm_st) == ST_RELEASED);
endmodule

bind key_release_encoder kenc_checker #(.CODE_W(CODE_W)) u_kenc_chk (
    .clk      (clk),
    .rst      (rst),
    .key_code (key_code),
    .new_key  (new_key),
    .fsm_st   (fsm_state)
);

// File: tb/tb_key_release_encoder.sv
module tb_key_release_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int NK  = 16;
    localparam int DEB = 4;
    localparam logic [NK-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NK-1:0] keys_n = ONES;
    logic [3:0]    key_code;
    logic          new_key;

    int vectors = 0;
    int fails   = 0;
    int pulses  = 0;
    bit done    = 0;

    key_release_encoder #(.NUM_KEYS(NK), .DEB_LEN(DEB)) dut (
        .clk      (clk),
        .rst      (rst),
        .keys_n   (keys_n),
        .key_code (key_code),
        .new_key  (new_key)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [NK-1:0] mq[$];
    logic [NK-1:0] m_cand, m_deb;
    int m_cnt, m_st, m_idx, m_code;
    bit m_nk;

    always @(posedge clk) begin
        if (rst) begin
            mq = {ONES, ONES};
            m_cand = ONES; m_deb = ONES; m_cnt = 0;
            m_st = 0; m_idx = 0; m_code = 0; m_nk = 0;
        end else begin
            logic [NK-1:0] down;
            logic [NK-1:0] older;
            int nlow, first;
            down = ~m_deb;
            nlow = $countones(down);
            first = -1;
            for (int i = 0; i < NK; i++) if (down[i] && first < 0) first = i;
            m_nk = 0;
            case (m_st)
                0: if (nlow == 1) begin m_idx = first; m_st = 1; end
                   else if (nlow > 1) m_st = 3;
                1: if (nlow == 0) m_st = 2;
                   else if (!(nlow == 1 && first == m_idx)) m_st = 3;
                2: begin m_code = (m_idx + 1) % 16; m_nk = 1; m_st = 0; end
                default: if (nlow == 0) m_st = 0;
            endcase
            older = mq[0];
            if (older != m_cand) begin m_cand = older; m_cnt = 0; end
            else if (m_cnt == DEB - 1) m_deb = m_cand;
            else m_cnt++;
            void'(mq.pop_front());
            mq.push_back(keys_n);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle model comparison (R2, R5, R8)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(key_code == 4'(m_code), "R2 model code", key_code, m_code);
            chk(new_key == m_nk, "R5 model strobe", new_key, m_nk);
        end
        if (new_key) pulses++;
    end

    task automatic tap(input int b, input int expc);
        int p0;
        int c0;
        p0 = pulses;
        c0 = key_code;
        @(negedge clk); keys_n = ONES; keys_n[b] = 1'b0;
        repeat (12) @(negedge clk);
        chk(key_code == 4'(c0), "R3 code while held", key_code, c0);
        chk(pulses == p0, "R3 no strobe while held", pulses, p0);
        keys_n = ONES;
        repeat (12) @(negedge clk);
        chk(key_code == 4'(expc), (b == 15) ? "R4 top key wraps" : "R2 released code",
            key_code, expc);
        chk(pulses == p0 + 1, "R5 one strobe", pulses, p0 + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        chk(key_code == 4'd0, "R1 reset code", key_code, 0);
        chk(new_key == 1'b0, "R1 reset strobe", new_key, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        tap(1, 2);
        tap(5, 6);
        tap(0, 1);
        tap(14, 15);
        tap(15, 0);
        tap(9, 10);

        // R7: short glitch
        p0 = pulses;
        @(negedge clk); keys_n = ONES; keys_n[3] = 1'b0;
        repeat (2) @(negedge clk); keys_n = ONES;
        repeat (20) @(negedge clk);
        chk(pulses == p0, "R7 glitch strobe", pulses, p0);
        chk(key_code == 4'd10, "R7 glitch code", key_code, 10);

        // R6: chord at capture
        p0 = pulses;
        keys_n = ONES; keys_n[2] = 1'b0; keys_n[6] = 1'b0;
        repeat (15) @(negedge clk);
        keys_n = ONES; keys_n[6] = 1'b0;
        repeat (15) @(negedge clk);
        keys_n = ONES;
        repeat (15) @(negedge clk);
        chk(pulses == p0, "R6 chord strobe", pulses, p0);
        chk(key_code == 4'd10, "R6 chord code", key_code, 10);
        tap(7, 8);

        // R9: second key joins held key
        p0 = pulses;
        keys_n = ONES; keys_n[2] = 1'b0;
        repeat (12) @(negedge clk);
        keys_n[9] = 1'b0;
        repeat (12) @(negedge clk);
        keys_n = ONES;
        repeat (15) @(negedge clk);
        chk(pulses == p0, "R9 joined key strobe", pulses, p0);
        chk(key_code == 4'd8, "R9 joined key code", key_code, 8);

        // R1: reset mid-run clears held code
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(key_code == 4'd0, "R1 reset clears code", key_code, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        tap(12, 13);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule